// File: doc/BRIEF.md
# Cluster Power-Off Sequencer

This block walks a processor core and its private L2 cache through the steps that have to finish before the system removes the cluster's power. The steps are fixed and taken in order. First the core asks for an L2 flush. Then the flush completes. Then the core halts in its wait-for-interrupt state. Last, the cluster leaves the coherency domain, which is seen when the coherency request and its acknowledge are both low. Once all of that has happened, the block raises a ready-for-power-off flag to the system and holds it.

The same block combines the external reset with the system's active-low soft reset into one CPU reset. That reset passes through a short synchroniser, and it restarts the sequence. The block also owns a power-down clock-gate bit, which is set when the system asserts its soft reset while the power-off request is pending. All inputs are treated as asynchronous to the block clock. Each event input is re-timed before the step logic uses it.

Top module: `pwr_off_seq`

## Requirements
- R1: `cpu_rst` follows `ext_rst | ~soft_rst_n` through exactly two clock edges, both when it rises and when it falls.
- R2: While `cpu_rst` is high, the sequence returns to step 0 (`seq_step` = 0, idle) on the next edge. The event synchronisers clear to 0 on the same edge.
- R3: Each event input passes through three flops before it is used. A level applied just after edge 0 can move the step no earlier than edge 4.
- R4: From step 0 (idle) the only way forward is `flush_req`. Flush-done, halt and coherency-exit events are ignored in step 0.
- R5: Step 1 (flushing) moves to step 2 only when `flush_done` is seen.
- R6: Step 2 (awaiting halt) moves to step 3 only when `core_halted` is seen.
- R7: Step 3 (leaving coherency) moves to step 4 only when `coh_req` and `coh_ack` are both low. Either one high holds step 3.
- R8: Step 4 (power-off requested) is held until a CPU reset.
- R9: `off_ready` is 1 exactly when `seq_step` = 4.
- R10: The step advances by at most one per clock, even when every event is present at once.
- R11: `pd_clk_gate` sets on an edge where `soft_rst_n` is low and the step is 4. It stays set while `soft_rst_n` stays low. It clears on the first edge with `soft_rst_n` high or `ext_rst` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| ext_rst | input | 1 | External reset, active high |
| soft_rst_n | input | 1 | System soft reset of the cluster, active low |
| flush_req | input | 1 | Core asks for L2 flush (asynchronous) |
| flush_done | input | 1 | L2 flush completed (asynchronous) |
| core_halted | input | 1 | Core halted in wait-for-interrupt (asynchronous) |
| coh_req | input | 1 | Coherency-domain request (asynchronous) |
| coh_ack | input | 1 | Coherency-domain acknowledge (asynchronous) |
| cpu_rst | output | 1 | Combined, synchronised CPU reset |
| seq_step | output | 3 | Current step: 0 idle, 1 flushing, 2 awaiting halt, 3 leaving coherency, 4 power-off requested |
| off_ready | output | 1 | Cluster is ready for power removal |
| pd_clk_gate | output | 1 | Power-down clock-gate bit |

## Verification
Two events can fall in the same cycle. The first is the soft reset that sets the clock-gate bit in step 4. The second is the combined CPU reset that this same soft reset launches and that sends the sequence back to idle. The bench drops `soft_rst_n` while the block sits in step 4. It then expects the gate to set one edge later, the CPU reset to rise on the second edge and the step to clear on the third, with the gate still held. A second collision presents every event at once when the CPU reset releases. The block must then step through 1, 2, 3, 4 on consecutive clocks and not jump. A behavioural model, built from delay queues, is compared against every output on every clock.

// File: rtl/pos_pkg.sv
package pos_pkg;

    localparam int EVT_SYNC_STAGES = 3;
    localparam int RST_SYNC_STAGES = 2;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_FLUSH  = 3'd1,
        ST_HALT   = 3'd2,
        ST_UNCOH  = 3'd3,
        ST_OFFREQ = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic coh_quiet;
        logic halted;
        logic flush_done;
        logic flush_req;
    } evt_t;

    localparam int EVT_W = $bits(evt_t);

    function automatic seq_state_e next_step(seq_state_e cur, evt_t ev);
        seq_state_e nxt;
        nxt = cur;
        case (cur)
            ST_IDLE:   if (ev.flush_req)  nxt = ST_FLUSH;
            ST_FLUSH:  if (ev.flush_done) nxt = ST_HALT;
            ST_HALT:   if (ev.halted)     nxt = ST_UNCOH;
            ST_UNCOH:  if (ev.coh_quiet)  nxt = ST_OFFREQ;
            ST_OFFREQ: nxt = ST_OFFREQ;
            default:   nxt = ST_IDLE;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/pos_rst_sync.sv
module pos_rst_sync #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic raw_rst,
    output logic rst_o
);
    logic [DEPTH-1:0] stage_q;

    always_ff @(posedge clk) begin
        stage_q <= {stage_q[DEPTH-2:0], raw_rst};
    end

    assign rst_o = stage_q[DEPTH-1];
endmodule

// File: rtl/pos_evt_sync.sv
module pos_evt_sync #(
    parameter int WIDTH = 4,
    parameter int DEPTH = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [DEPTH-1:0] chain_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                chain_q <= '0;
            end else begin
                chain_q <= {chain_q[DEPTH-2:0], d_i[g]};
            end
        end

        assign q_o[g] = chain_q[DEPTH-1];
    end
endmodule

// File: rtl/pos_fsm.sv
module pos_fsm
    import pos_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  evt_t       evt_i,
    output seq_state_e state_o
);
    seq_state_e state_q;
    logic [2:0] step_bits;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= next_step(state_q, evt_i);
        end
    end

    assign state_o   = state_q;
    assign step_bits = state_q;

    // R10: a change of step is always a single increment
    a_r10_single_step: assert property (@(posedge clk) disable iff (rst)
        (step_bits != $past(step_bits)) |-> (step_bits == $past(step_bits) + 3'd1));

    // R8: power-off request is sticky outside reset
    a_r8_offreq_held: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_OFFREQ) |=> (state_q == ST_OFFREQ));

    // R4: idle waits for the flush request only
    a_r4_idle_waits: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !evt_i.flush_req) |=> (state_q == ST_IDLE));

    // R7: coherency exit needs both handshake lines low
    a_r7_uncoh_waits: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_UNCOH && !evt_i.coh_quiet) |=> (state_q == ST_UNCOH));
endmodule

// File: rtl/pos_gate.sv
module pos_gate (
    input  logic clk,
    input  logic ext_rst,
    input  logic soft_rst_n,
    input  logic at_offreq,
    output logic gate_o
);
    logic gate_q;

    always_ff @(posedge clk) begin
        if (ext_rst) begin
            gate_q <= 1'b0;
        end else begin
            gate_q <= ~soft_rst_n & (gate_q | at_offreq);
        end
    end

    assign gate_o = gate_q;

    // R11: gate only ever follows a low soft reset
    a_r11_needs_soft_low: assert property (@(posedge clk) disable iff (ext_rst)
        gate_o |-> !$past(soft_rst_n));

    // R11: soft reset during the power-off request sets the gate
    a_r11_sets_on_offreq: assert property (@(posedge clk) disable iff (ext_rst)
        (!soft_rst_n && at_offreq) |=> gate_o);
endmodule

// File: rtl/pwr_off_seq.sv
module pwr_off_seq
    import pos_pkg::*;
#(
    parameter int EVT_STAGES = EVT_SYNC_STAGES,
    parameter int RST_STAGES = RST_SYNC_STAGES
) (
    input  logic       clk,
    input  logic       ext_rst,
    input  logic       soft_rst_n,
    input  logic       flush_req,
    input  logic       flush_done,
    input  logic       core_halted,
    input  logic       coh_req,
    input  logic       coh_ack,
    output logic       cpu_rst,
    output logic [2:0] seq_step,
    output logic       off_ready,
    output logic       pd_clk_gate
);
    logic       raw_rst;
    evt_t       raw_evt;
    evt_t       sync_evt;
    logic [EVT_W-1:0] sync_bits;
    seq_state_e state;

    assign raw_rst = ext_rst | ~soft_rst_n;

    pos_rst_sync #(.DEPTH(RST_STAGES)) u_rst_sync (
        .clk     (clk),
        .raw_rst (raw_rst),
        .rst_o   (cpu_rst)
    );

    always_comb begin
        raw_evt            = '0;
        raw_evt.flush_req  = flush_req;
        raw_evt.flush_done = flush_done;
        raw_evt.halted     = core_halted;
        raw_evt.coh_quiet  = ~coh_req & ~coh_ack;
    end

    pos_evt_sync #(.WIDTH(EVT_W), .DEPTH(EVT_STAGES)) u_evt_sync (
        .clk (clk),
        .rst (cpu_rst),
        .d_i (raw_evt),
        .q_o (sync_bits)
    );

    assign sync_evt = evt_t'(sync_bits);

    pos_fsm u_fsm (
        .clk     (clk),
        .rst     (cpu_rst),
        .evt_i   (sync_evt),
        .state_o (state)
    );

    pos_gate u_gate (
        .clk        (clk),
        .ext_rst    (ext_rst),
        .soft_rst_n (soft_rst_n),
        .at_offreq  (state == ST_OFFREQ),
        .gate_o     (pd_clk_gate)
    );

    assign seq_step  = state;
    assign off_ready = (state == ST_OFFREQ);

    // R2: a CPU reset always lands the sequence in idle
    a_r2_idle_after_rst: assert property (@(posedge clk)
        cpu_rst |=> (seq_step == 3'd0));
endmodule

// File: tb/tb_pwr_off_seq.sv
`timescale 1ns/1ps
module tb_pwr_off_seq;
    logic clk = 1'b0;
    logic ext_rst = 1'b1, soft_rst_n = 1'b1;
    logic flush_req = 1'b0, flush_done = 1'b0, core_halted = 1'b0;
    logic coh_req = 1'b1, coh_ack = 1'b1;
    logic cpu_rst, off_ready, pd_clk_gate;
    logic [2:0] seq_step;

    int checks = 0;
    int errors = 0;
    bit armed = 1'b0;
    bit done_flag = 1'b0;

    always #2 clk = ~clk;

    pwr_off_seq dut (
        .clk(clk), .ext_rst(ext_rst), .soft_rst_n(soft_rst_n),
        .flush_req(flush_req), .flush_done(flush_done), .core_halted(core_halted),
        .coh_req(coh_req), .coh_ack(coh_ack),
        .cpu_rst(cpu_rst), .seq_step(seq_step), .off_ready(off_ready),
        .pd_clk_gate(pd_clk_gate)
    );

    // behavioural reference: delay queues for the reset and the events
    bit        rq[$] = '{1'b1, 1'b1};
    bit [3:0]  eq[$] = '{4'd0, 4'd0, 4'd0};
    int        m_state = 0;
    bit        m_rst = 1'b1;
    bit        m_gate = 1'b0;

    always @(posedge clk) begin
        bit       o_rst;
        int       o_state;
        bit [3:0] seen;
        o_rst   = m_rst;
        o_state = m_state;
        seen    = eq[0];
        rq.push_back(ext_rst | !soft_rst_n);
        void'(rq.pop_front());
        m_rst = rq[0];
        if (o_rst) eq = '{4'd0, 4'd0, 4'd0};
        else begin
            eq.push_back({!coh_req && !coh_ack, core_halted, flush_done, flush_req});
            void'(eq.pop_front());
        end
        if (o_rst) m_state = 0;
        else if (o_state < 4 && seen[o_state]) m_state = o_state + 1;
        m_gate = ext_rst ? 1'b0 : (!soft_rst_n && (m_gate || o_state == 4));
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (armed) begin
            chk("R1 cpu_rst vs model", cpu_rst, m_rst);
            chk("R10 seq_step vs model", seq_step, m_state);
            chk("R9 off_ready vs model", off_ready, m_state == 4);
            chk("R11 pd_clk_gate vs model", pd_clk_gate, m_gate);
        end
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        wait_cyc(5);
        armed = 1'b1;
        ext_rst = 1'b0;
        wait_cyc(3);
        // R2 reset state
        chk("R2 step after reset", seq_step, 0);
        chk("R2 off_ready after reset", off_ready, 0);
        chk("R1 cpu_rst released", cpu_rst, 0);

        // R4: events other than the flush request are ignored in idle
        flush_done = 1'b1; core_halted = 1'b1; coh_req = 1'b0; coh_ack = 1'b0;
        wait_cyc(8);
        chk("R4 idle ignores other events", seq_step, 0);
        flush_done = 1'b0; core_halted = 1'b0; coh_req = 1'b1;

        // R3: three-stage synchroniser latency
        flush_req = 1'b1;
        wait_cyc(3);
        chk("R3 no move before edge 4", seq_step, 0);
        wait_cyc(1);
        chk("R3 moved at edge 4", seq_step, 1);

        // R5, R6, R7
        wait_cyc(6);
        chk("R5 waits for flush done", seq_step, 1);
        flush_done = 1'b1; core_halted = 1'b1;
        wait_cyc(4);
        chk("R5 flush done taken", seq_step, 2);
        wait_cyc(1);
        chk("R6 halt taken", seq_step, 3);
        wait_cyc(8);
        chk("R7 held by request", seq_step, 3);
        coh_req = 1'b0; coh_ack = 1'b1;
        wait_cyc(8);
        chk("R7 held by acknowledge", seq_step, 3);
        coh_ack = 1'b0;
        wait_cyc(4);
        chk("R7 exit when both low", seq_step, 4);
        chk("R9 ready in step 4", off_ready, 1);
        flush_req = 1'b0; flush_done = 1'b0; core_halted = 1'b0; coh_req = 1'b1;
        wait_cyc(20);
        chk("R8 step 4 held", seq_step, 4);

        // R11 and R1 collide with R2: soft reset while power-off pending
        soft_rst_n = 1'b0;
        wait_cyc(1);
        chk("R11 gate set", pd_clk_gate, 1);
        chk("R1 reset not yet", cpu_rst, 0);
        wait_cyc(1);
        chk("R1 reset after two edges", cpu_rst, 1);
        wait_cyc(1);
        chk("R2 idle after reset", seq_step, 0);
        chk("R11 gate held", pd_clk_gate, 1);
        wait_cyc(4);
        chk("R11 gate still held", pd_clk_gate, 1);

        // R10: every event present when reset releases
        flush_req = 1'b1; flush_done = 1'b1; core_halted = 1'b1;
        coh_req = 1'b0; coh_ack = 1'b0;
        soft_rst_n = 1'b1;
        wait_cyc(1);
        chk("R11 gate clears on release", pd_clk_gate, 0);
        chk("R1 reset still high", cpu_rst, 1);
        for (int i = 0; i < 20 && seq_step != 3'd1; i++) wait_cyc(1);
        chk("R10 reached step 1", seq_step, 1);
        wait_cyc(1);
        chk("R10 step 2 next", seq_step, 2);
        wait_cyc(1);
        chk("R10 step 3 next", seq_step, 3);
        wait_cyc(1);
        chk("R10 step 4 next", seq_step, 4);

        // R11: external reset clears the gate while soft reset stays low
        soft_rst_n = 1'b0;
        wait_cyc(1);
        chk("R11 gate set again", pd_clk_gate, 1);
        ext_rst = 1'b1;
        wait_cyc(1);
        chk("R11 ext reset clears gate", pd_clk_gate, 0);
        wait_cyc(3);
        chk("R2 idle under ext reset", seq_step, 0);
        ext_rst = 1'b0; soft_rst_n = 1'b1;
        flush_req = 1'b0; flush_done = 1'b0; core_halted = 1'b0;
        wait_cyc(4);
        chk("R1 reset released again", cpu_rst, 0);
        chk("R9 not ready in idle", off_ready, 0);
        wait_cyc(2);
        finish_run();
    end
endmodule